// File: doc/BRIEF.md
# Sequential Unsigned 32x32 Multiplier

The block forms the full 64-bit unsigned product of two 32-bit operands with one shared half-width multiplier. A start pulse captures both operands. The half-width multiplier then produces one partial product per clock: low times low, high times low, low times high, and high times high. A final combine step adds the two cross products, shifts them into place, and folds the carries into the upper word. The upper 32 bits go to the high result register and the lower 32 bits go to the low result register.

A caller pulses `start_i` while `busy_o` is low and then waits for the one-cycle `done_o` pulse. Both result registers keep their value until the next product completes. The block computes unsigned products only. A request flagged as signed is refused: the block pulses `err_o` and starts no computation.

Top module: `seqmul_u32`

## Requirements
- R1: While reset is applied and after it is released, `busy_o`, `done_o` and `err_o` are 0 and both result registers read 0.
- R2: For an accepted request, `{res_hi_o, res_lo_o}` equals the unsigned 64-bit product of `opa_i` and `opb_i` as sampled on the start edge.
- R3: `busy_o` is 1 from the edge that accepts the start up to the fifth edge after it. `done_o` is 1 for exactly the one cycle that follows that fifth edge.
- R4: `busy_o` and `done_o` are never 1 together, and `busy_o` falls on the edge where `done_o` rises.
- R5: A start pulse that arrives while `busy_o` is 1 is ignored. The operands and signed flag it carries have no effect, it raises no error, and it leads to no second `done_o` pulse.
- R6: A start with `signed_i` = 1 while idle makes `err_o` 1 for exactly the cycle after that edge. `busy_o` stays 0 and `done_o` is not raised.
- R7: A carry out of the sum of the two cross products adds 2^16 to the high result (for example, 0xFFFFFFFF squared gives 0xFFFFFFFE_00000001).
- R8: A carry out of the low-word sum adds 1 to the high result (for example, 0x0000FFFF times 0x0001FFFF gives 0x00000001_FFFD0001).
- R9: Except on the edge that raises `done_o`, the result registers hold their value, including across refused and ignored requests.
- R10: A start given during the cycle in which `done_o` is 1 is accepted and gives its own correct result five edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse, sampled while idle |
| signed_i | input | 1 | Request asks for a signed product (refused) |
| opa_i | input | 32 | Multiplicand |
| opb_i | input | 32 | Multiplier |
| busy_o | output | 1 | A product is being formed |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse for a refused signed request |
| res_hi_o | output | 32 | Upper 32 bits of the last product |
| res_lo_o | output | 32 | Lower 32 bits of the last product |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the middle of a computation while carrying different operands and a signed flag. If it were not filtered, it would corrupt the captured operands or raise an error. The bench fires that pulse two cycles into a run, checks that `err_o` stays low, checks that the original product comes out, and then watches for a stray second completion. The two carry-fold paths can only be told apart with chosen operands, so each path gets an operand pair that overflows that sum alone.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;
   typedef enum logic [0:0] {
      SQ_IDLE = 1'b0,
      SQ_RUN  = 1'b1
   } sq_state_e;

   localparam int unsigned SQ_TERMS = 4;
endpackage

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl #(
   parameter int unsigned TERMS = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_i,
   input  logic                          signed_i,
   output logic                          load_o,
   output logic                          pp_we_o,
   output logic [$clog2(TERMS)-1:0]      term_o,
   output logic                          fold_o,
   output logic                          busy_o,
   output logic                          err_o
);
   import seqmul_pkg::*;

   localparam int unsigned CW = $clog2(TERMS + 1);
   localparam int unsigned TW = $clog2(TERMS);

   sq_state_e      state_q;
   logic [CW-1:0]  cnt_q;
   logic           accept;
   logic           refuse;

   assign accept  = (state_q == SQ_IDLE) && start_i && !signed_i;
   assign refuse  = (state_q == SQ_IDLE) && start_i &&  signed_i;
   assign load_o  = accept;
   assign busy_o  = (state_q == SQ_RUN);
   assign pp_we_o = busy_o && (cnt_q < CW'(TERMS));
   assign fold_o  = busy_o && (cnt_q == CW'(TERMS));
   assign term_o  = cnt_q[TW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         cnt_q   <= '0;
         err_o   <= 1'b0;
      end else begin
         err_o <= refuse;
         case (state_q)
            SQ_IDLE: begin
               if (accept) begin
                  state_q <= SQ_RUN;
                  cnt_q   <= '0;
               end
            end
            default: begin
               if (cnt_q == CW'(TERMS)) begin
                  state_q <= SQ_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/seqmul_pp.sv
module seqmul_pp #(
   parameter int unsigned HALF_W = 16
) (
   input  logic [2*HALF_W-1:0] opa_i,
   input  logic [2*HALF_W-1:0] opb_i,
   input  logic [1:0]          term_i,
   output logic [2*HALF_W-1:0] pp_o
);
   logic [HALF_W-1:0] a_half [2];
   logic [HALF_W-1:0] b_half [2];

   for (genvar h = 0; h < 2; h++) begin : g_split
      assign a_half[h] = opa_i[h*HALF_W +: HALF_W];
      assign b_half[h] = opb_i[h*HALF_W +: HALF_W];
   end

   // term 0: a_lo*b_lo, 1: a_hi*b_lo, 2: a_lo*b_hi, 3: a_hi*b_hi
   always_comb begin
      pp_o = (2*HALF_W)'(a_half[term_i[0]]) * (2*HALF_W)'(b_half[term_i[1]]);
   end
endmodule

// File: rtl/seqmul_fold.sv
module seqmul_fold #(
   parameter int unsigned HALF_W = 16
) (
   input  logic [2*HALF_W-1:0] pp_ll_i,
   input  logic [2*HALF_W-1:0] pp_hl_i,
   input  logic [2*HALF_W-1:0] pp_lh_i,
   input  logic [2*HALF_W-1:0] pp_hh_i,
   output logic [2*HALF_W-1:0] hi_o,
   output logic [2*HALF_W-1:0] lo_o
);
   localparam int unsigned W = 2 * HALF_W;

   logic [W:0]    cross_sum;
   logic [W:0]    low_sum;
   logic          cross_cy;
   logic          low_cy;

   always_comb begin
      cross_sum = {1'b0, pp_hl_i} + {1'b0, pp_lh_i};
      cross_cy  = cross_sum[W];
      low_sum   = {1'b0, pp_ll_i} + {1'b0, cross_sum[HALF_W-1:0], {HALF_W{1'b0}}};
      low_cy    = low_sum[W];
      lo_o      = low_sum[W-1:0];
      hi_o      = pp_hh_i
                + W'(cross_sum[W-1:HALF_W])
                + (W'(cross_cy) << HALF_W)
                + W'(low_cy);
   end
endmodule

// File: rtl/seqmul_u32.sv
module seqmul_u32 #(
   parameter int unsigned HALF_W = 16,
   localparam int unsigned W     = 2 * HALF_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         signed_i,
   input  logic [W-1:0] opa_i,
   input  logic [W-1:0] opb_i,
   output logic         busy_o,
   output logic         done_o,
   output logic         err_o,
   output logic [W-1:0] res_hi_o,
   output logic [W-1:0] res_lo_o
);
   import seqmul_pkg::*;

   localparam int unsigned TW = $clog2(SQ_TERMS);

   if (HALF_W < 2) begin : g_bad_width
      $error("seqmul_u32: HALF_W must be at least 2");
   end

   logic          load;
   logic          pp_we;
   logic          fold;
   logic [TW-1:0] term;
   logic [W-1:0]  opa_q;
   logic [W-1:0]  opb_q;
   logic [W-1:0]  pp;
   logic [W-1:0]  pp_q [SQ_TERMS];
   logic [W-1:0]  fold_hi;
   logic [W-1:0]  fold_lo;

   seqmul_ctrl #(.TERMS(SQ_TERMS)) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .signed_i (signed_i),
      .load_o   (load),
      .pp_we_o  (pp_we),
      .term_o   (term),
      .fold_o   (fold),
      .busy_o   (busy_o),
      .err_o    (err_o)
   );

   seqmul_pp #(.HALF_W(HALF_W)) pp_i (
      .opa_i  (opa_q),
      .opb_i  (opb_q),
      .term_i (term),
      .pp_o   (pp)
   );

   seqmul_fold #(.HALF_W(HALF_W)) fold_i (
      .pp_ll_i (pp_q[0]),
      .pp_hl_i (pp_q[1]),
      .pp_lh_i (pp_q[2]),
      .pp_hh_i (pp_q[3]),
      .hi_o    (fold_hi),
      .lo_o    (fold_lo)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         opa_q <= '0;
         opb_q <= '0;
      end else if (load) begin
         opa_q <= opa_i;
         opb_q <= opb_i;
      end
   end

   for (genvar t = 0; t < SQ_TERMS; t++) begin : g_pp_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pp_q[t] <= '0;
         end else if (pp_we && (term == TW'(t))) begin
            pp_q[t] <= pp;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_hi_o <= '0;
         res_lo_o <= '0;
         done_o   <= 1'b0;
      end else begin
         done_o <= fold;
         if (fold) begin
            res_hi_o <= fold_hi;
            res_lo_o <= fold_lo;
         end
      end
   end
endmodule

// File: rtl/seqmul_u32_chk.sv
module seqmul_u32_chk #(
   parameter int unsigned W   = 32,
   parameter int unsigned LAT = 5
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic         signed_i,
   input logic         busy_o,
   input logic         done_o,
   input logic         err_o,
   input logic [W-1:0] res_hi_o,
   input logic [W-1:0] res_lo_o
);
   logic [7:0] run_len;

   always_ff @(posedge clk) begin
      if (!rst_n)      run_len <= '0;
      else if (busy_o) run_len <= run_len + 1'b1;
      else             run_len <= '0;
   end

   // R4
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && done_o));

   // R3
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R3
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && !signed_i) |=> busy_o);

   // R3
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (run_len == 8'(LAT)));

   // R6
   refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && signed_i) |=> (err_o && !busy_o));

   // R6
   err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o);

   // R5
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_o) |=> !err_o);

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(res_hi_o) && $stable(res_lo_o)));
endmodule

bind seqmul_u32 seqmul_u32_chk #(.W(W), .LAT(5)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .signed_i (signed_i),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .err_o    (err_o),
   .res_hi_o (res_hi_o),
   .res_lo_o (res_lo_o)
);

// File: tb/seqmul_u32_tb.sv
module seqmul_u32_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        signed_i = 1'b0;
   logic [31:0] opa_i = '0;
   logic [31:0] opb_i = '0;
   logic        busy_o, done_o, err_o;
   logic [31:0] res_hi_o, res_lo_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   seqmul_u32 dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .signed_i (signed_i),
      .opa_i    (opa_i),
      .opb_i    (opb_i),
      .busy_o   (busy_o),
      .done_o   (done_o),
      .err_o    (err_o),
      .res_hi_o (res_hi_o),
      .res_lo_o (res_lo_o)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] result();
      return {res_hi_o, res_lo_o};
   endfunction

   // drive a start at a negedge; returns after the accepting edge (next negedge)
   task automatic pulse_start(input logic [31:0] a, input logic [31:0] b, input logic sg);
      opa_i = a; opb_i = b; signed_i = sg; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; signed_i = 1'b0;
   endtask

   // called right after the accepting edge; checks timing and result
   task automatic await_result(input logic [63:0] exp, input string req);
      check("R3", "busy after accept", 64'(busy_o), 64'd1);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check("R3", "busy during run", 64'({busy_o, done_o}), 64'b10);
      end
      @(negedge clk);
      check("R3", "done after fifth edge", 64'(done_o), 64'd1);
      check("R4", "busy low with done", 64'(busy_o), 64'd0);
      check(req, "product", result(), exp);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", "flags in reset", 64'({busy_o, done_o, err_o}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "flags after reset", 64'({busy_o, done_o, err_o}), 64'd0);
      check("R1", "result after reset", result(), 64'd0);
   endtask

   task automatic t_basic();
      logic [31:0] av [5] = '{32'd0, 32'd7, 32'h1234_5678, 32'h8000_0000, 32'hDEAD_BEEF};
      logic [31:0] bv [5] = '{32'hFFFF_FFFF, 32'd6, 32'h9ABC_DEF0, 32'd2, 32'h0000_0001};
      for (int i = 0; i < 5; i++) begin
         pulse_start(av[i], bv[i], 1'b0);
         await_result(64'(av[i]) * 64'(bv[i]), "R2");
         @(negedge clk);
         check("R3", "done single cycle", 64'(done_o), 64'd0);
         check("R9", "result held after done", result(), 64'(av[i]) * 64'(bv[i]));
      end
   endtask

   task automatic t_carries();
      // R7: both cross products large, their sum overflows
      pulse_start(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
      await_result(64'hFFFF_FFFE_0000_0001, "R7");
      @(negedge clk);
      // R8: low-word sum overflows, cross sum does not
      pulse_start(32'h0000_FFFF, 32'h0001_FFFF, 1'b0);
      await_result(64'h0000_0001_FFFD_0001, "R8");
      @(negedge clk);
   endtask

   task automatic t_busy_ignore();
      logic [63:0] exp;
      exp = 64'(32'hCAFE_0001) * 64'(32'h0BAD_F00D);
      pulse_start(32'hCAFE_0001, 32'h0BAD_F00D, 1'b0);
      @(negedge clk);
      // R5: stray start with new operands and signed flag mid-run
      opa_i = 32'h1111_1111; opb_i = 32'h2222_2222; signed_i = 1'b1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; signed_i = 1'b0;
      check("R5", "no error from start while busy", 64'(err_o), 64'd0);
      for (int i = 0; i < 2; i++) @(negedge clk);
      check("R5", "still running", 64'(busy_o), 64'd1);
      @(negedge clk);
      check("R5", "done on schedule", 64'(done_o), 64'd1);
      check("R5", "original product kept", result(), exp);
      for (int i = 0; i < 7; i++) begin
         @(negedge clk);
         check("R5", "no second run", 64'({busy_o, done_o}), 64'd0);
      end
   endtask

   task automatic t_signed();
      logic [63:0] prev;
      prev = result();
      pulse_start(32'h0000_0003, 32'h0000_0005, 1'b1);
      check("R6", "err after refused start", 64'({err_o, busy_o}), 64'b10);
      @(negedge clk);
      check("R6", "err single cycle", 64'(err_o), 64'd0);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         check("R6", "no run after refusal", 64'({busy_o, done_o}), 64'd0);
      end
      check("R9", "result unchanged by refusal", result(), prev);
   endtask

   task automatic t_back_to_back();
      pulse_start(32'h0000_1000, 32'h0000_2000, 1'b0);
      await_result(64'h0200_0000, "R2");
      // R10: new start issued in the done cycle
      pulse_start(32'hFFFF_0000, 32'h0001_0001, 1'b0);
      check("R10", "second accepted", 64'(busy_o), 64'd1);
      await_result(64'(32'hFFFF_0000) * 64'(32'h0001_0001), "R10");
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_basic();
      t_carries();
      t_busy_ignore();
      t_signed();
      t_back_to_back();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule